// File: doc/BRIEF.md
# Four-Channel DMA Channel Sequencer

This block keeps the control and status state of four independent DMA channels and steps each one through idle, running, halted, aborted and finished. A host reaches every channel through a 16-bit register port. Writing a channel's control register starts, halts, resumes or aborts it. Each channel owns a transfer counter that stands in for the data mover. The counter is loaded from a length register at start. In free-running mode it counts down once per clock. In request mode it counts down once per rising edge of that channel's request input. Address generation and bus traffic are outside the block.

When a count runs out, the channel raises a one-cycle done pulse and posts completion status. A software abort of a running channel posts error status and loads a fixed error code. It also raises a one-cycle error strobe toward the host, with the channel number and that channel's interrupt vector beside it. The host clears status flags by writing ones to them.

Register map. The address is {channel[1:0], select[2:0]}. Select 0 reads {status, error code}. Select 1 is control, select 2 is operation mode, select 3 is the vector (each in the low byte). Select 4 is the transfer length. Select 5 reads the remaining count. Other selects read 0.

Top module: `dmac_ctl`

## Requirements
- R1: After reset every readable register of every channel reads 0, and done_pulse and err_stb are low.
- R2: A write to select 0 with host_be[1] set clears each status bit 7:4 whose matching bit of host_wdata[15:12] is 1 and leaves the others. The error code byte (select 0, low byte) is read-only, so low-byte writes there change nothing.
- R3: A control write with bit 7 set starts the channel. Status bit 3 reads 1, the remaining count loads from the length register, the error code clears, and the other status bits are kept.
- R4: In free-running mode (operation bit 1 = 0) the count drops by one each clock from the cycle after start. The step that finds a count of 1 or less completes the channel: status bits 7:5 set, bit 3 clears, control bits 7:6 clear, and done_pulse for that channel is high for one cycle. With length L, done is seen L cycles after the start write.
- R5: In request mode (operation bit 1 = 1) each 0-to-1 edge of the channel's dreq bit, while the channel runs, makes exactly one step. A level held high makes no further steps, and the count never climbs without a host write.
- R6: A control write with bit 5 set halts a running channel. The count freezes and status bit 3 stays 1. A later control write with bit 6 set resumes counting.
- R7: A control write with bit 4 set to a running channel (or one started by the same write) aborts it. Status bits 7 and 4 set, bit 3 clears, the error code becomes 0x11, control bits 7:6 clear, and err_stb is high for one cycle with err_chan and err_vec naming the channel and its vector.
- R8: An abort request to a channel that is not running has no effect on its status, its error code or err_stb.
- R9: When completion and a host status clear land on the same clock, the completion flags win. Bits that completion does not set are still cleared.
- R10: Channels are independent: starting, aborting or finishing one does not change another's registers or timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_we | input | 1 | Register write strobe |
| host_addr | input | 5 | {channel, register select} |
| host_be | input | 2 | Byte enables (bit 1 upper byte, bit 0 lower byte) |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data for host_addr (combinational) |
| dreq | input | 4 | Per-channel transfer request lines |
| done_pulse | output | 4 | One-cycle completion pulse per channel |
| err_stb | output | 1 | One-cycle abort error strobe |
| err_chan | output | 2 | Channel that raised err_stb |
| err_vec | output | 8 | Vector register of that channel |

## Verification
Completion of a running count and a host write-one-to-clear of the status byte can meet on the same edge. The bench starts a channel that already holds an error flag, counts the cycles to its final step, and times a clear of all four flags to that exact edge. It then expects the completion flags set and the stale error flag gone. A second overlap, a start and an abort in one control write, is judged by the error strobe and by the resulting status and error code.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  // register selects within a channel
  localparam logic [2:0] SEL_STAT = 3'd0;
  localparam logic [2:0] SEL_CTRL = 3'd1;
  localparam logic [2:0] SEL_OPER = 3'd2;
  localparam logic [2:0] SEL_VEC  = 3'd3;
  localparam logic [2:0] SEL_LEN  = 3'd4;
  localparam logic [2:0] SEL_REM  = 3'd5;

  // control bits
  localparam int CTL_START = 7;
  localparam int CTL_CONT  = 6;
  localparam int CTL_HALT  = 5;
  localparam int CTL_ABORT = 4;
  // operation bit selecting request-edge mode
  localparam int OPR_REQ   = 1;

  // upper status nibble (bits 7:4) patterns
  localparam logic [3:0] STAT_FIN = 4'b1110;
  localparam logic [3:0] STAT_ERR = 4'b1001;

  localparam logic [7:0] ABORT_CODE = 8'h11;
endpackage

// File: rtl/dmac_rst_sync.sv
module dmac_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_s_n = sync_q[1];
endmodule

// File: rtl/dmac_chan.sv
module dmac_chan
  import dmac_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_stat,
  input  logic          wr_ctrl,
  input  logic          wr_oper,
  input  logic          wr_vec,
  input  logic          wr_len,
  input  logic [15:0]   wdata,
  input  logic          dreq,
  output logic [7:0]    stat_o,
  output logic [7:0]    errc_o,
  output logic [7:0]    ctrl_o,
  output logic [7:0]    oper_o,
  output logic [7:0]    vec_o,
  output logic [CW-1:0] len_o,
  output logic [CW-1:0] rem_o,
  output logic          active_o,
  output logic          halted_o,
  output logic          done_o,
  output logic          abort_o
);
  logic [3:0]    stat_q, stat_n;
  logic [7:0]    errc_q, errc_n, ctrl_q, ctrl_n, oper_q, vec_q;
  logic [CW-1:0] len_q, rem_q, rem_n;
  logic          act_q, act_n, halt_q, halt_n, req_q;
  logic          done_q, done_n, abort_q, abort_n;

  logic start, cont, halt_req, abort_req, req_rise, step, do_abort, fin;

  always_comb begin
    start     = wr_ctrl && wdata[CTL_START];
    cont      = wr_ctrl && wdata[CTL_CONT];
    halt_req  = wr_ctrl && wdata[CTL_HALT];
    abort_req = wr_ctrl && wdata[CTL_ABORT];
    req_rise  = dreq && !req_q;
    step      = act_q && !halt_q && (oper_q[OPR_REQ] ? req_rise : 1'b1);
    do_abort  = abort_req && (act_q || start);
    fin       = step && (rem_q <= CW'(1)) && !start && !do_abort;
  end

  always_comb begin
    stat_n  = stat_q & ~(wr_stat ? wdata[15:12] : 4'h0);
    errc_n  = errc_q;
    ctrl_n  = wr_ctrl ? wdata[7:0] : ctrl_q;
    act_n   = act_q;
    halt_n  = halt_q;
    rem_n   = rem_q;
    done_n  = 1'b0;
    abort_n = 1'b0;

    if (fin) begin
      act_n             = 1'b0;
      stat_n            = stat_n | STAT_FIN;
      ctrl_n[7:6]       = 2'b00;
      done_n            = 1'b1;
    end else if (step) begin
      rem_n = rem_q - CW'(1);
    end

    if (start) begin
      act_n  = 1'b1;
      rem_n  = len_q;
      errc_n = 8'h00;
      halt_n = 1'b0;
    end
    if (cont) halt_n = 1'b0;
    if (halt_req && (act_q || start)) halt_n = 1'b1;

    if (do_abort) begin
      act_n       = 1'b0;
      halt_n      = 1'b0;
      stat_n      = stat_n | STAT_ERR;
      errc_n      = ABORT_CODE;
      ctrl_n[7:6] = 2'b00;
      abort_n     = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q  <= '0;
      errc_q  <= '0;
      ctrl_q  <= '0;
      oper_q  <= '0;
      vec_q   <= '0;
      len_q   <= '0;
      rem_q   <= '0;
      act_q   <= 1'b0;
      halt_q  <= 1'b0;
      req_q   <= 1'b0;
      done_q  <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      stat_q  <= stat_n;
      errc_q  <= errc_n;
      ctrl_q  <= ctrl_n;
      rem_q   <= rem_n;
      act_q   <= act_n;
      halt_q  <= halt_n;
      req_q   <= dreq;
      done_q  <= done_n;
      abort_q <= abort_n;
      if (wr_oper) oper_q <= wdata[7:0];
      if (wr_vec)  vec_q  <= wdata[7:0];
      if (wr_len)  len_q  <= wdata[CW-1:0];
    end
  end

  assign stat_o   = {stat_q, act_q, 3'b000};
  assign errc_o   = errc_q;
  assign ctrl_o   = ctrl_q;
  assign oper_o   = oper_q;
  assign vec_o    = vec_q;
  assign len_o    = len_q;
  assign rem_o    = rem_q;
  assign active_o = act_q;
  assign halted_o = halt_q;
  assign done_o   = done_q;
  assign abort_o  = abort_q;
endmodule

// File: rtl/dmac_ctl.sv
module dmac_ctl
  import dmac_pkg::*;
#(
  parameter int NCH = 4,
  parameter int CW  = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   host_we,
  input  logic [$clog2(NCH)+2:0] host_addr,
  input  logic [1:0]             host_be,
  input  logic [15:0]            host_wdata,
  output logic [15:0]            host_rdata,
  input  logic [NCH-1:0]         dreq,
  output logic [NCH-1:0]         done_pulse,
  output logic                   err_stb,
  output logic [$clog2(NCH)-1:0] err_chan,
  output logic [7:0]             err_vec
);
  localparam int CHW = $clog2(NCH);
  localparam int AW  = CHW + 3;

  logic rst_s_n;
  logic [CHW-1:0] a_chan;
  logic [2:0]     a_sel;

  logic [7:0]             stat_w [NCH];
  logic [7:0]             errc_w [NCH];
  logic [7:0]             ctrl_w [NCH];
  logic [7:0]             oper_w [NCH];
  logic [7:0]             vec_w  [NCH];
  logic [NCH-1:0][CW-1:0] len_w;
  logic [NCH-1:0][CW-1:0] rem_w;
  logic [NCH-1:0]         act_w, halt_w, abort_w;

  dmac_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_s_n(rst_s_n));

  assign a_chan = host_addr[AW-1:3];
  assign a_sel  = host_addr[2:0];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic we_c;
    assign we_c = host_we && (a_chan == CHW'(c));

    dmac_chan #(.CW(CW)) u_ch (
      .clk      (clk),
      .rst_n    (rst_s_n),
      .wr_stat  (we_c && a_sel == SEL_STAT && host_be[1]),
      .wr_ctrl  (we_c && a_sel == SEL_CTRL && host_be[0]),
      .wr_oper  (we_c && a_sel == SEL_OPER && host_be[0]),
      .wr_vec   (we_c && a_sel == SEL_VEC  && host_be[0]),
      .wr_len   (we_c && a_sel == SEL_LEN  && host_be[0]),
      .wdata    (host_wdata),
      .dreq     (dreq[c]),
      .stat_o   (stat_w[c]),
      .errc_o   (errc_w[c]),
      .ctrl_o   (ctrl_w[c]),
      .oper_o   (oper_w[c]),
      .vec_o    (vec_w[c]),
      .len_o    (len_w[c]),
      .rem_o    (rem_w[c]),
      .active_o (act_w[c]),
      .halted_o (halt_w[c]),
      .done_o   (done_pulse[c]),
      .abort_o  (abort_w[c])
    );
  end

  logic [15:0] len_x, rem_x;

  always_comb begin
    len_x = '0;
    rem_x = '0;
    len_x[CW-1:0] = len_w[a_chan];
    rem_x[CW-1:0] = rem_w[a_chan];
    case (a_sel)
      SEL_STAT: host_rdata = {stat_w[a_chan], errc_w[a_chan]};
      SEL_CTRL: host_rdata = {8'h00, ctrl_w[a_chan]};
      SEL_OPER: host_rdata = {8'h00, oper_w[a_chan]};
      SEL_VEC:  host_rdata = {8'h00, vec_w[a_chan]};
      SEL_LEN:  host_rdata = len_x;
      SEL_REM:  host_rdata = rem_x;
      default:  host_rdata = 16'h0000;
    endcase
  end

  always_comb begin
    err_chan = '0;
    for (int c = NCH - 1; c >= 0; c--)
      if (abort_w[c]) err_chan = CHW'(c);
  end

  assign err_stb = |abort_w;
  assign err_vec = vec_w[err_chan];
endmodule

// File: rtl/dmac_ctl_chk.sv
module dmac_ctl_chk #(
  parameter int NCH = 4,
  parameter int CW  = 16
) (
  input logic                   clk,
  input logic                   rst_s_n,
  input logic                   host_we,
  input logic                   err_stb,
  input logic [$clog2(NCH)-1:0] err_chan,
  input logic [NCH-1:0]         done_pulse,
  input logic [NCH-1:0]         act_w,
  input logic [NCH-1:0]         halt_w,
  input logic [NCH-1:0][CW-1:0] rem_w
);
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_s_n)
    (|done_pulse) |=> ((done_pulse & $past(done_pulse)) == '0)); // R4

  AST_ERR_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_s_n)
    err_stb |-> $past(host_we)); // R7

  AST_ERR_CHAN_IDLE: assert property (@(posedge clk) disable iff (!rst_s_n)
    err_stb |-> !act_w[err_chan]); // R7

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    AST_DONE_LEAVES_IDLE: assert property (@(posedge clk) disable iff (!rst_s_n)
      done_pulse[c] |-> !act_w[c]); // R4

    AST_HALT_FREEZES: assert property (@(posedge clk) disable iff (!rst_s_n)
      (halt_w[c] && !host_we) |=> $stable(rem_w[c])); // R6

    AST_COUNT_NO_RISE: assert property (@(posedge clk) disable iff (!rst_s_n)
      (act_w[c] && $past(act_w[c]) && !$past(host_we)) |-> (rem_w[c] <= $past(rem_w[c]))); // R5
  end
endmodule

bind dmac_ctl dmac_ctl_chk #(.NCH(NCH), .CW(CW)) u_chk (.*);

// File: tb/tb_dmac_ctl.sv
module tb_dmac_ctl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_we;
  logic [4:0]  host_addr;
  logic [1:0]  host_be;
  logic [15:0] host_wdata;
  logic [15:0] host_rdata;
  logic [3:0]  dreq;
  logic [3:0]  done_pulse;
  logic        err_stb;
  logic [1:0]  err_chan;
  logic [7:0]  err_vec;

  always #4 clk = ~clk;

  dmac_ctl dut (.*);

  int checks = 0;
  int errors = 0;
  int unsigned cyc = 0;
  bit done_flag = 0;

  always @(posedge clk) cyc <= cyc + 1;

  typedef struct packed {
    logic [1:0]  kind;   // 1 done, 2 error strobe
    logic [1:0]  chan;
    logic [7:0]  vec;
    logic [31:0] at;
  } exp_t;
  exp_t q[$];

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%04h expected 0x%04h", req, what, act, exp);
    end
  endtask

  task automatic rd(input int ch, input int rg, output logic [15:0] d);
    host_addr = {2'(ch), 3'(rg)};
    #1 d = host_rdata;
  endtask

  task automatic rchk(input string req, input int ch, input int rg, input logic [15:0] exp);
    logic [15:0] d;
    rd(ch, rg, d);
    chk(req, $sformatf("ch%0d sel%0d", ch, rg), d, exp);
  endtask

  task automatic push(input int kind, input int ch, input logic [7:0] v, input int unsigned at);
    exp_t e;
    e.kind = 2'(kind);
    e.chan = 2'(ch);
    e.vec  = v;
    e.at   = at;
    q.push_back(e);
  endtask

  // driver: a write, with an optional expected event dly cycles after its edge
  task automatic wr(input int ch, input int rg, input logic [1:0] be, input logic [15:0] d,
                    input int kind = 0, input int dly = 0, input logic [7:0] v = 8'h00);
    @(negedge clk);
    host_we    = 1'b1;
    host_addr  = {2'(ch), 3'(rg)};
    host_be    = be;
    host_wdata = d;
    if (kind != 0) push(kind, ch, v, cyc + 1 + dly);
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic match(input int kind, input int ch, input logic [7:0] v);
    int idx = -1;
    string req = (kind == 1) ? "R4" : "R7";
    checks++;
    for (int i = 0; i < q.size(); i++)
      if (idx < 0 && q[i].kind == 2'(kind) && q[i].chan == 2'(ch)) idx = i;
    if (idx < 0) begin
      errors++;
      $display("FAIL %s unexpected event kind %0d ch%0d at cycle %0d: actual present expected none", req, kind, ch, cyc);
    end else begin
      if (q[idx].at != cyc || (kind == 2 && q[idx].vec != v)) begin
        errors++;
        $display("FAIL %s event kind %0d ch%0d: actual cycle %0d vec 0x%02h expected cycle %0d vec 0x%02h",
                 req, kind, ch, cyc, v, q[idx].at, q[idx].vec);
      end
      q.delete(idx);
    end
  endtask

  // monitor: pops expectations as pulses appear
  always @(negedge clk) begin
    if (rst_n && !done_flag) begin
      for (int c = 0; c < 4; c++)
        if (done_pulse[c]) match(1, c, 8'h00);
      if (err_stb) match(2, int'(err_chan), err_vec);
    end
  end

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual timeout expected end of run");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; host_we = 1'b0; host_addr = '0; host_be = '0; host_wdata = '0; dreq = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    for (int c = 0; c < 4; c++) begin
      rchk("R1", c, 0, 16'h0000);
      rchk("R1", c, 1, 16'h0000);
      rchk("R1", c, 5, 16'h0000);
    end
    chk("R1", "done/err", {11'd0, done_pulse, err_stb}, 16'h0000);

    // R3, R4 free-running channel 0, length 5
    wr(0, 3, 2'b01, 16'h0042);
    wr(0, 4, 2'b11, 16'd5);
    wr(0, 1, 2'b01, 16'h0080, 1, 5);
    rchk("R3", 0, 0, 16'h0800);
    rchk("R3", 0, 5, 16'd5);
    rchk("R3", 0, 1, 16'h0080);
    repeat (6) @(negedge clk);
    rchk("R4", 0, 0, 16'hE000);
    rchk("R4", 0, 1, 16'h0000);

    // R2 write-one-to-clear, error byte read-only
    wr(0, 0, 2'b10, 16'h4000);
    rchk("R2", 0, 0, 16'hA000);
    wr(0, 0, 2'b01, 16'h00FF);
    rchk("R2", 0, 0, 16'hA000);
    wr(0, 0, 2'b11, 16'hA000);
    rchk("R2", 0, 0, 16'h0000);

    // R8 abort on idle channel
    wr(0, 1, 2'b01, 16'h0010);
    repeat (2) @(negedge clk);
    rchk("R8", 0, 0, 16'h0000);

    // R5 request mode on channel 2
    wr(2, 3, 2'b01, 16'h0077);
    wr(2, 2, 2'b01, 16'h0002);
    wr(2, 4, 2'b11, 16'd3);
    wr(2, 1, 2'b01, 16'h0080);
    rchk("R5", 2, 5, 16'd3);
    dreq[2] = 1'b1;
    @(negedge clk);
    rchk("R5", 2, 5, 16'd2);
    repeat (3) @(negedge clk);
    rchk("R5", 2, 5, 16'd2);
    dreq[2] = 1'b0;
    @(negedge clk);
    dreq[2] = 1'b1;
    @(negedge clk);
    rchk("R5", 2, 5, 16'd1);
    dreq[2] = 1'b0;
    repeat (3) @(negedge clk);
    rchk("R5", 2, 5, 16'd1);
    push(1, 2, 8'h00, cyc + 1);
    dreq[2] = 1'b1;
    repeat (2) @(negedge clk);
    dreq[2] = 1'b0;
    rchk("R5", 2, 0, 16'hE000);

    // R6 halt and resume on channel 1
    wr(1, 3, 2'b01, 16'h005A);
    wr(1, 4, 2'b11, 16'd20);
    wr(1, 1, 2'b01, 16'h0080);
    repeat (3) @(negedge clk);
    wr(1, 1, 2'b01, 16'h0020);
    rchk("R6", 1, 5, 16'd15);
    repeat (5) @(negedge clk);
    rchk("R6", 1, 5, 16'd15);
    rchk("R6", 1, 0, 16'h0800);
    wr(1, 1, 2'b01, 16'h0040, 1, 15);
    repeat (17) @(negedge clk);
    rchk("R6", 1, 0, 16'hE000);
    rchk("R4", 1, 1, 16'h0000);

    // R7 abort of a running channel
    wr(1, 0, 2'b10, 16'hF000);
    wr(1, 1, 2'b01, 16'h0080);
    repeat (2) @(negedge clk);
    wr(1, 1, 2'b01, 16'h0010, 2, 0, 8'h5A);
    rchk("R7", 1, 0, 16'h9011);
    rchk("R7", 1, 1, 16'h0010);

    // R9 completion meets status clear on one edge
    wr(1, 4, 2'b11, 16'd6);
    wr(1, 1, 2'b01, 16'h0080, 1, 6);
    rchk("R3", 1, 0, 16'h9800);
    repeat (4) @(negedge clk);
    wr(1, 0, 2'b10, 16'hF000);
    rchk("R9", 1, 0, 16'hE000);

    // R10 independent channels: abort 3 while 0 runs
    wr(3, 3, 2'b01, 16'h0033);
    wr(3, 4, 2'b11, 16'd10);
    wr(3, 1, 2'b01, 16'h0080);
    wr(0, 4, 2'b11, 16'd4);
    wr(0, 1, 2'b01, 16'h0080, 1, 4);
    wr(3, 1, 2'b01, 16'h0010, 2, 0, 8'h33);
    repeat (4) @(negedge clk);
    rchk("R10", 0, 0, 16'hE000);
    rchk("R10", 3, 0, 16'h9011);
    rchk("R10", 2, 0, 16'hE000);
    wr(3, 1, 2'b01, 16'h0010);
    rchk("R8", 3, 0, 16'h9011);

    // R7 start and abort in one write
    wr(2, 1, 2'b01, 16'h0090, 2, 0, 8'h77);
    rchk("R7", 2, 0, 16'hF011);
    rchk("R7", 2, 1, 16'h0010);

    repeat (3) @(negedge clk);
    chk("R4", "pending events", 16'(q.size()), 16'd0);
    done_flag = 1;
    finish_run();
  end
endmodule